// File: doc/BRIEF.md
# Bit-Sliced Ripple-Carry ALU

This block is a combinational arithmetic-logic unit of parameterised width (32 bits by default). It is built from identical one-bit slices. Every slice forms the bitwise AND, the bitwise OR and a full-adder sum of its two operand bits at the same time. A small per-bit selector then passes one of these to the result bit, as chosen by a 2-bit operation code shared by all slices. The slices are joined by a ripple carry chain. The carry entering the least significant slice comes from a port, and the carry leaving the most significant slice is reported.

A surrounding datapath drives the two operands, the carry input and the operation code. It reads the result and the carry output in the same cycle, because the block holds no state. The carry-in port lets a wider addition be built from several of these units. It also lets a caller form A + B + 1 for increment-style arithmetic.

Top module: `ripple_alu`

## Requirements
- R1: With op_sel = 2'b00 the result equals the bitwise AND of opnd_a and opnd_b.
- R2: With op_sel = 2'b01 the result equals the bitwise OR of opnd_a and opnd_b.
- R3: With op_sel = 2'b10 the result equals the low WIDTH bits of opnd_a + opnd_b + carry_in.
- R4: With op_sel = 2'b10, carry_out equals bit WIDTH of opnd_a + opnd_b + carry_in. For example, all ones plus zero with carry_in = 1 gives result 0 and carry_out 1.
- R5: A carry made in bit 0 ripples through every slice. For example, all ones plus 1 with carry_in = 0 clears every result bit, and 0x7FFFFFFF + 1 sets only the top bit with no carry out.
- R6: With op_sel = 2'b11 (reserved) the result is all zeros and carry_out is 0 for any operands and carry_in.
- R7: For op_sel 2'b00, 2'b01 and 2'b11, carry_out is 0 whatever the operands and carry_in.
- R8: For op_sel 2'b00, 2'b01 and 2'b11, carry_in has no effect on the result.
- R9: The outputs are a pure function of the present inputs. A new input vector is reflected at the outputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand |
| carry_in | input | 1 | Carry into the least significant slice |
| op_sel | input | 2 | Operation: 00 AND, 01 OR, 10 add, 11 reserved (zero) |
| result | output | WIDTH | Selected operation result |
| carry_out | output | 1 | Carry from the most significant slice; 0 unless adding |

## Verification
The bench targets the full-length carry paths: all ones plus one, all ones plus zero with a carry in, and a carry into the sign bit. A slice whose carry is not chained to its neighbour fails these vectors, and so does a chain with one link broken; both leave stray ones in the result or lose the carry out. It also drives carry_in high during the logical and reserved codes. A design that lets the adder carry leak to carry_out, or that decodes the reserved code as one of the others, shows a non-zero carry or result there. Random operands under every code catch a swapped select encoding or a wrong sum or carry gate.

// File: rtl/alu_pkg.sv
// Package: shared operation encoding for the bit-sliced ALU.
// Assumes a 2-bit operation field decoded identically by every slice.
package alu_pkg;
    typedef enum logic [1:0] {
        OP_AND  = 2'b00,
        OP_OR   = 2'b01,
        OP_ADD  = 2'b10,
        OP_ZERO = 2'b11
    } alu_op_e;
endpackage

// File: rtl/alu_full_adder.sv
// Module: one-bit full adder written as gates.
// The sum is the parity of the three inputs. The carry is the majority of
// the three inputs. Assumes nothing about timing; purely combinational.
module alu_full_adder (
    input  logic a_bit,
    input  logic b_bit,
    input  logic c_bit,
    output logic sum_bit,
    output logic carry_bit
);
    // Sum: odd number of ones among the inputs.
    assign sum_bit   = a_bit ^ b_bit ^ c_bit;
    // Carry: at least two inputs set.
    assign carry_bit = (a_bit & b_bit) | (a_bit & c_bit) | (b_bit & c_bit);
endmodule

// File: rtl/alu_bit_slice.sv
// Module: one bit of the ALU.
// It forms AND, OR and the full-adder sum in parallel and picks one by the
// shared operation code. The reserved code yields 0. The slice carry is
// always produced, so the chain ripples regardless of the operation.
module alu_bit_slice
    import alu_pkg::*;
(
    input  logic    a_bit,
    input  logic    b_bit,
    input  logic    c_in,
    input  alu_op_e op,
    output logic    r_bit,
    output logic    c_out
);
    logic and_bit;
    logic or_bit;
    logic sum_bit;

    // Logical candidates, evaluated regardless of op.
    assign and_bit = a_bit & b_bit;
    assign or_bit  = a_bit | b_bit;

    alu_full_adder u_fa (
        .a_bit     (a_bit),
        .b_bit     (b_bit),
        .c_bit     (c_in),
        .sum_bit   (sum_bit),
        .carry_bit (c_out)
    );

    // Per-bit selector: route the requested candidate to the output.
    always_comb begin
        unique case (op)
            OP_AND:  r_bit = and_bit;
            OP_OR:   r_bit = or_bit;
            OP_ADD:  r_bit = sum_bit;
            default: r_bit = 1'b0;
        endcase
    end
endmodule

// File: rtl/ripple_alu.sv
// Module: WIDTH-bit ALU assembled from one-bit slices joined by a ripple carry.
// The carry into slice i+1 is the carry out of slice i. The final carry is
// reported only for the add code. Purely combinational; no clock or reset.
module ripple_alu
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic             carry_in,
    input  logic [1:0]       op_sel,
    output logic [WIDTH-1:0] result,
    output logic             carry_out
);
    localparam int CHAIN_LEN = WIDTH + 1;

    alu_op_e              op_dec;
    logic [CHAIN_LEN-1:0] chain;

    // Decode the raw select into the shared operation type.
    assign op_dec   = alu_op_e'(op_sel);
    // Seed the ripple chain with the external carry.
    assign chain[0] = carry_in;

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        alu_bit_slice u_slice (
            .a_bit (opnd_a[i]),
            .b_bit (opnd_b[i]),
            .c_in  (chain[i]),
            .op    (op_dec),
            .r_bit (result[i]),
            .c_out (chain[i+1])
        );
    end

    // Report the top carry only while adding.
    assign carry_out = (op_dec == OP_ADD) & chain[WIDTH];
endmodule

// File: rtl/ripple_alu_chk.sv
// Module: assertion checker for ripple_alu, bound to every instance.
// It compares the ports against a behavioural view of each operation.
// It uses immediate checks because the block has no clock.
module ripple_alu_chk #(
    parameter int WIDTH = 32
) (
    input logic [WIDTH-1:0] opnd_a,
    input logic [WIDTH-1:0] opnd_b,
    input logic             carry_in,
    input logic [1:0]       op_sel,
    input logic [WIDTH-1:0] result,
    input logic             carry_out
);
    localparam int W1 = WIDTH + 1;

    logic [W1-1:0] ref_sum;

    // Behavioural wide sum used as the arithmetic reference.
    assign ref_sum = {1'b0, opnd_a} + {1'b0, opnd_b} + W1'(carry_in);

    // Check each operation's outputs whenever the inputs change.
    always_comb begin
        if (op_sel == 2'b00) begin
            AST_AND_RESULT: assert (result == (opnd_a & opnd_b)) else $error("AND mismatch"); // R1
        end
        if (op_sel == 2'b01) begin
            AST_OR_RESULT: assert (result == (opnd_a | opnd_b)) else $error("OR mismatch"); // R2
        end
        if (op_sel == 2'b10) begin
            AST_ADD_RESULT: assert (result == ref_sum[WIDTH-1:0]) else $error("sum mismatch"); // R3
            AST_ADD_CARRY: assert (carry_out == ref_sum[WIDTH]) else $error("carry mismatch"); // R4
        end
        if (op_sel == 2'b11) begin
            AST_RSVD_ZERO: assert (result == '0) else $error("reserved not zero"); // R6
        end
        if (op_sel != 2'b10) begin
            AST_LOGIC_NO_CARRY: assert (!carry_out) else $error("carry outside add"); // R7
        end
    end
endmodule

bind ripple_alu ripple_alu_chk #(.WIDTH(WIDTH)) u_chk (
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .carry_in  (carry_in),
    .op_sel    (op_sel),
    .result    (result),
    .carry_out (carry_out)
);

// File: tb/ripple_alu_tb.sv
// Bench: drives vectors on the rising edge and compares on the falling edge
// against a behavioural reference model using 64-bit integer arithmetic.
module ripple_alu_tb;
    localparam int WIDTH = 32;
    localparam logic [WIDTH-1:0] ONES = '1;

    logic             clk = 1'b0;
    logic [WIDTH-1:0] opnd_a = '0;
    logic [WIDTH-1:0] opnd_b = '0;
    logic             carry_in = 1'b0;
    logic [1:0]       op_sel = 2'b00;
    logic [WIDTH-1:0] result;
    logic             carry_out;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 0;

    always #2.5 clk = ~clk;

    ripple_alu #(.WIDTH(WIDTH)) u_dut (
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .carry_in  (carry_in),
        .op_sel    (op_sel),
        .result    (result),
        .carry_out (carry_out)
    );

    // Reference model: returns {carry, result} computed behaviourally.
    function automatic logic [WIDTH:0] model(input logic [WIDTH-1:0] a,
                                             input logic [WIDTH-1:0] b,
                                             input logic ci, input logic [1:0] op);
        longint unsigned s;
        case (op)
            2'b00:   return {1'b0, a & b};
            2'b01:   return {1'b0, a | b};
            2'b10: begin
                s = longint'(a) + longint'(b) + longint'(ci);
                return s[WIDTH:0];
            end
            default: return '0;
        endcase
    endfunction

    // Apply one vector, wait for the falling edge and compare both outputs.
    task automatic run(input string tag, input logic [WIDTH-1:0] a,
                       input logic [WIDTH-1:0] b, input logic ci, input logic [1:0] op);
        logic [WIDTH:0] exp;
        @(posedge clk);
        opnd_a = a; opnd_b = b; carry_in = ci; op_sel = op;
        exp = model(a, b, ci, op);
        @(negedge clk);
        n_tests++;
        if ({carry_out, result} !== exp) begin
            n_fail++;
            $display("FAIL %s: op=%0d a=%h b=%h ci=%0b got carry=%0b result=%h exp carry=%0b result=%h",
                     tag, op, a, b, ci, carry_out, result, exp[WIDTH], exp[WIDTH-1:0]);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // Idle inputs: all zeros gives zero outputs (R9 combinational settle).
        run("R9_idle", '0, '0, 1'b0, 2'b00);
        // R1 / R2 corner patterns.
        run("R1", ONES, 32'h0F0F_A5A5, 1'b0, 2'b00);
        run("R2", '0, 32'h8000_0001, 1'b0, 2'b01);
        // R3 / R4: all ones plus zero with carry in wraps to zero with carry.
        run("R4_ones_cin", ONES, '0, 1'b1, 2'b10);
        run("R3_zero", '0, '0, 1'b0, 2'b10);
        run("R3_zero_cin", '0, '0, 1'b1, 2'b10);
        // R5: full-length ripple and carry into the top bit.
        run("R5_ones_plus1", ONES, 32'h1, 1'b0, 2'b10);
        run("R5_sign", 32'h7FFF_FFFF, 32'h1, 1'b0, 2'b10);
        run("R5_ones_ones_cin", ONES, ONES, 1'b1, 2'b10);
        // R6: reserved code is zero regardless of inputs.
        run("R6", ONES, ONES, 1'b1, 2'b11);
        // R7 / R8: carry_in high during logical codes.
        run("R7_and", ONES, ONES, 1'b1, 2'b00);
        run("R8_or", 32'h1234_5678, 32'h0, 1'b1, 2'b01);
        run("R8_and", 32'h0, 32'h0, 1'b1, 2'b00);
        // R9: back-to-back distinct vectors with no settling gap beyond one edge.
        run("R9_switch", 32'hDEAD_BEEF, 32'h2152_4111, 1'b0, 2'b10);
        // Random sweep over every code (R1, R2, R3, R4, R6, R7, R8).
        for (int k = 0; k < 2000; k++) begin
            logic [1:0] op;
            op = 2'(k % 4);
            run(op == 2'b00 ? "R1_rand" : op == 2'b01 ? "R2_rand" :
                op == 2'b10 ? "R3_R4_rand" : "R6_rand",
                $urandom, $urandom, 1'($urandom), op);
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule